// File: doc/BRIEF.md
# NAND Sector Code Check and Single-Bit Repair

This block judges a 512-byte NAND sector by its 3-byte Hamming check code. It takes two such codes in one valid/ready transfer: the code read back from the page's spare area and the code recomputed over the sector data as it arrived. It unpacks both into 32-bit words and forms their XOR, the syndrome. It counts the syndrome's set bits in a registered two-stage adder tree and then gives a 2-bit verdict. For a repairable single-bit error it also gives the byte offset within the sector and the bit position inside that byte.

A separate repair port lets the data path pass sector bytes through the block one at a time, each with its offset. Only the byte named by the last "repaired" verdict comes out with the indicated bit inverted. Every other byte passes unchanged. The block does not compute the code over the data, does not buffer the sector and does not drive the flash device.

Top module: `nand_code_check`

## Requirements
- R1: Each 24-bit code port carries byte k on bits 8k+7:8k. Each code is unpacked into a 32-bit word: byte 0 goes to bits 7:0, byte 1 to bits 23:16, the low nibble of byte 2 to bits 11:8 and the high nibble of byte 2 to bits 27:24. All other bits are zero. The syndrome is the XOR of the two words. An all-zero syndrome gives status 0 (OK).
- R2: A syndrome with exactly 12 bits set gives status 1 (repaired). The bit output is then syndrome bits 18:16 and the offset output is syndrome bits 27:19, a value from 0 to 511. For every other status, the offset and bit outputs are zero.
- R3: A syndrome with exactly one bit set gives status 2 (bad code), with offset and bit zero.
- R4: In the erased-page case the stored code unpacks to 0x0FFF0FFF (all three bytes 0xFF) and the computed code is all zero. This gives status 0 (OK), even though the syndrome has 24 bits set.
- R5: Any other nonzero syndrome gives status 3 (uncorrectable). This includes a stored code of all ones paired with a nonzero computed code, and a computed code of all ones paired with a stored code of all zero.
- R6: A transfer is taken at a rising edge where in_valid and in_ready are both high. The verdict appears on the outputs after the second rising edge following the transfer, together with a done pulse exactly one cycle wide. The verdict then holds until the next one.
- R7: in_ready is low from the transfer edge until the edge that raises done, and high otherwise.
- R8: When the held status is 1 and fix_offset equals the held offset, fix_out equals fix_in with the bit at the held bit index inverted.
- R9: When the held status is not 1, or fix_offset differs from the held offset, fix_out equals fix_in.
- R10: While rst_n is low at a rising edge, the block clears status to 0, offset and bit to 0 and done to 0, and in_ready is high after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Code pair offered |
| in_ready | output | 1 | Block can take a code pair |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the sector |
| done | output | 1 | One-cycle pulse: verdict updated |
| status | output | 2 | 0 OK, 1 repaired, 2 bad code, 3 uncorrectable |
| err_offset | output | 9 | Byte offset of the repaired bit |
| err_bit | output | 3 | Bit index of the repaired bit |
| fix_in | input | 8 | Sector byte on the repair port |
| fix_offset | input | 9 | Offset of that byte |
| fix_out | output | 8 | Byte after optional repair |

## Verification
The code pairs are of several kinds, and each kind separates the classifier branches from one another:
- Equal codes check the zero path.
- Constructed single-bit error codes at offsets 0, 511 and mid-sector, with several bit indices, confirm that 12 bits select repair and that the offset and bit fields land in the right place. Offset 511 also checks the top of the range.
- Lone flipped bits in each byte and nibble position separate the bad-code class from the others and expose any mistake in the nibble unpacking.
- The erased pattern is run beside two near-misses, all ones against a nonzero code and zero against all ones, which shows that the exception needs both conditions.
- Repair-port bytes at the matching offset, at a neighbouring offset, and after a non-repair verdict separate the flip from the pass-through.
- A per-clock model of done and in_ready catches any latency or pulse-width slip.

// File: rtl/nand_code_check_pkg.sv
// Shared types and helpers for the sector code checker.
// Assumes a 3-byte code laid out byte k at bits 8k+7:8k.
package nand_code_check_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_FIXED    = 2'd1,
        ST_BADCODE  = 2'd2,
        ST_MULTI    = 2'd3
    } chk_status_e;

    localparam int unsigned CODE_W = 24;
    localparam int unsigned WORD_W = 32;

    // Spread a packed 3-byte code into the 32-bit comparison word.
    function automatic logic [WORD_W-1:0] spread_code(input logic [CODE_W-1:0] c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[7:0]   = c[7:0];
        w[23:16] = c[15:8];
        w[11:8]  = c[19:16];
        w[27:24] = c[23:20];
        return w;
    endfunction

endpackage

// File: rtl/nand_syn_stage.sv
// First pipeline stage: forms the syndrome, counts set bits per group,
// and flags the erased-page code pair. All results are registered.
// Assumes load_i is only raised when the stage may accept new codes.
module nand_syn_stage
    import nand_code_check_pkg::*;
#(
    parameter int unsigned GRP_W  = 8,
    localparam int unsigned GROUPS = WORD_W / GRP_W,
    localparam int unsigned GCNT_W = $clog2(GRP_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [CODE_W-1:0]       stored_i,
    input  logic [CODE_W-1:0]       calc_i,
    output logic                    vld_o,
    output logic [WORD_W-1:0]       syn_o,
    output logic                    erased_o,
    output logic [GROUPS*GCNT_W-1:0] gcnt_o
);

    localparam logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;

    logic [WORD_W-1:0] stored_w;
    logic [WORD_W-1:0] calc_w;
    logic [WORD_W-1:0] syn_d;

    // Unpack both codes and take the difference.
    always_comb begin
        stored_w = spread_code(stored_i);
        calc_w   = spread_code(calc_i);
        syn_d    = stored_w ^ calc_w;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GCNT_W-1:0] cnt_d;

        // Count the ones in this slice of the syndrome.
        always_comb begin
            cnt_d = '0;
            for (int b = 0; b < GRP_W; b++) begin
                cnt_d = cnt_d + GCNT_W'(syn_d[g*GRP_W + b]);
            end
        end

        // Register the slice count on a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gcnt_o[g*GCNT_W +: GCNT_W] <= '0;
            end else if (load_i) begin
                gcnt_o[g*GCNT_W +: GCNT_W] <= cnt_d;
            end
        end
    end

    // Register syndrome, erased flag and the stage valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o    <= 1'b0;
            syn_o    <= '0;
            erased_o <= 1'b0;
        end else begin
            vld_o <= load_i;
            if (load_i) begin
                syn_o    <= syn_d;
                erased_o <= (stored_w == ERASED_WORD) && (calc_w == '0);
            end
        end
    end

endmodule

// File: rtl/nand_classify_stage.sv
// Second pipeline stage: sums the group counts and turns the syndrome
// into a verdict with the error location. Holds the verdict between
// results and pulses done for one cycle per result.
module nand_classify_stage
    import nand_code_check_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned GRP_W        = 8,
    localparam int unsigned OFS_W  = $clog2(SECTOR_BYTES),
    localparam int unsigned BIT_W  = 3,
    localparam int unsigned GROUPS = WORD_W / GRP_W,
    localparam int unsigned GCNT_W = $clog2(GRP_W + 1),
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1),
    localparam int unsigned HALF   = WORD_W / 2,
    localparam int unsigned SINGLE_CNT = OFS_W + BIT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [WORD_W-1:0]        syn_i,
    input  logic                     erased_i,
    input  logic [GROUPS*GCNT_W-1:0] gcnt_i,
    output logic                     done_o,
    output chk_status_e              status_o,
    output logic [OFS_W-1:0]         ofs_o,
    output logic [BIT_W-1:0]         bit_o
);

    logic [CNT_W-1:0] total;
    chk_status_e      st_d;
    logic [OFS_W-1:0] ofs_d;
    logic [BIT_W-1:0] bit_d;

    // Add up the per-group counts.
    always_comb begin
        total = '0;
        for (int g = 0; g < GROUPS; g++) begin
            total = total + CNT_W'(gcnt_i[g*GCNT_W +: GCNT_W]);
        end
    end

    // Pick the verdict from the bit count and the erased flag.
    always_comb begin
        st_d  = ST_MULTI;
        ofs_d = '0;
        bit_d = '0;
        if (syn_i == '0) begin
            st_d = ST_OK;
        end else if (total == CNT_W'(SINGLE_CNT)) begin
            st_d  = ST_FIXED;
            bit_d = syn_i[HALF +: BIT_W];
            ofs_d = syn_i[HALF + BIT_W +: OFS_W];
        end else if (total == CNT_W'(1)) begin
            st_d = ST_BADCODE;
        end else if (erased_i) begin
            st_d = ST_OK;
        end
    end

    // Hold the verdict and pulse done when a new one lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            status_o <= ST_OK;
            ofs_o    <= '0;
            bit_o    <= '0;
        end else begin
            done_o <= vld_i;
            if (vld_i) begin
                status_o <= st_d;
                ofs_o    <= ofs_d;
                bit_o    <= bit_d;
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    idle_location_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != ST_FIXED) |-> (ofs_o == '0 && bit_o == '0));

endmodule

// File: rtl/nand_fix_port.sv
// Repair port: inverts one bit of a passing byte when the held verdict
// names that byte's offset. Purely combinational.
module nand_fix_port
    import nand_code_check_pkg::*;
#(
    parameter int unsigned OFS_W = 9,
    localparam int unsigned BIT_W = 3
) (
    input  chk_status_e        status_i,
    input  logic [OFS_W-1:0]   ofs_i,
    input  logic [BIT_W-1:0]   bit_i,
    input  logic [7:0]         byte_i,
    input  logic [OFS_W-1:0]   byte_ofs_i,
    output logic [7:0]         byte_o
);

    // Build the flip mask only for the matching byte of a repair verdict.
    always_comb begin
        byte_o = byte_i;
        if (status_i == ST_FIXED && byte_ofs_i == ofs_i) begin
            byte_o[bit_i] = ~byte_i[bit_i];
        end
    end

endmodule

// File: rtl/nand_code_check.sv
// Top of the sector code checker. Takes a stored/computed code pair by
// valid/ready, reports a verdict two edges later with a done pulse,
// and offers a byte repair port driven by the held verdict.
// Assumes one code pair in flight at a time.
module nand_code_check
    import nand_code_check_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned GRP_W        = 8,
    localparam int unsigned OFS_W  = $clog2(SECTOR_BYTES),
    localparam int unsigned BIT_W  = 3,
    localparam int unsigned GROUPS = WORD_W / GRP_W,
    localparam int unsigned GCNT_W = $clog2(GRP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [23:0]       stored_code,
    input  logic [23:0]       calc_code,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFS_W-1:0]  err_offset,
    output logic [BIT_W-1:0]  err_bit,
    input  logic [7:0]        fix_in,
    input  logic [OFS_W-1:0]  fix_offset,
    output logic [7:0]        fix_out
);

    logic                     busy_q;
    logic                     accept;
    logic                     s1_vld;
    logic [WORD_W-1:0]        s1_syn;
    logic                     s1_erased;
    logic [GROUPS*GCNT_W-1:0] s1_gcnt;
    chk_status_e              st_q;

    assign in_ready = !busy_q;
    assign accept   = in_valid && in_ready;
    assign status   = st_q;

    // Block new transfers from acceptance until the verdict lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
        end else if (s1_vld) begin
            busy_q <= 1'b0;
        end
    end

    nand_syn_stage #(.GRP_W(GRP_W)) u_syn (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .stored_i (stored_code),
        .calc_i   (calc_code),
        .vld_o    (s1_vld),
        .syn_o    (s1_syn),
        .erased_o (s1_erased),
        .gcnt_o   (s1_gcnt)
    );

    nand_classify_stage #(.SECTOR_BYTES(SECTOR_BYTES), .GRP_W(GRP_W)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (s1_vld),
        .syn_i    (s1_syn),
        .erased_i (s1_erased),
        .gcnt_i   (s1_gcnt),
        .done_o   (done),
        .status_o (st_q),
        .ofs_o    (err_offset),
        .bit_o    (err_bit)
    );

    nand_fix_port #(.OFS_W(OFS_W)) u_fix (
        .status_i   (st_q),
        .ofs_i      (err_offset),
        .bit_i      (err_bit),
        .byte_i     (fix_in),
        .byte_ofs_i (fix_offset),
        .byte_o     (fix_out)
    );

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 done);

    // R9
    fix_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_FIXED) |-> (fix_out == fix_in));

endmodule

// File: tb/nand_code_check_tb.sv
`timescale 1ns/1ps
module nand_code_check_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  err_offset;
    logic [2:0]  err_bit;
    logic [7:0]  fix_in = '0;
    logic [8:0]  fix_offset = '0;
    logic [7:0]  fix_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit [1:0] hs_hist = 2'b00;
    logic [1:0] last_st = 2'd0;
    logic [8:0] last_ofs = '0;
    logic [2:0] last_bit = '0;

    always #2.5 clk = ~clk;

    nand_code_check dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .stored_code(stored_code), .calc_code(calc_code), .done(done),
        .status(status), .err_offset(err_offset), .err_bit(err_bit),
        .fix_in(fix_in), .fix_offset(fix_offset), .fix_out(fix_out)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference: verdict {status, offset, bit} from the two codes.
    function automatic logic [13:0] ref_verdict(input logic [23:0] s, input logic [23:0] c);
        longint ws, wc, x;
        int ones;
        ws = s[7:0] + (longint'(s[15:8]) << 16) + (longint'(s[19:16]) << 8) + (longint'(s[23:20]) << 24);
        wc = c[7:0] + (longint'(c[15:8]) << 16) + (longint'(c[19:16]) << 8) + (longint'(c[23:20]) << 24);
        x = ws ^ wc;
        ones = 0;
        for (int i = 0; i < 32; i++) ones += int'((x >> i) & 1);
        if (x == 0) return 14'd0;
        if (ones == 12) return {2'd1, 9'((x >> 19) & 511), 3'((x >> 16) & 7)};
        if (ones == 1) return {2'd2, 12'd0};
        if (ws == 64'h0FFF0FFF && wc == 0) return 14'd0;
        return {2'd3, 12'd0};
    endfunction

    // Code with computed code zero that marks a single error at (o, b).
    function automatic logic [23:0] err_code(input int o, input int b);
        logic [11:0] up, lo;
        up = 12'((o << 3) | b);
        lo = ~up;
        return {up[11:8], lo[11:8], up[7:0], lo[7:0]};
    endfunction

    // Per-clock model of done (R6) and in_ready idle level.
    always @(negedge clk) begin
        if (!finished) begin
            check("R6 done timing", done == hs_hist[1], done, hs_hist[1]);
            hs_hist = {hs_hist[0], in_valid & in_ready};
        end
    end

    task automatic run_case(input logic [23:0] s, input logic [23:0] c, input string req);
        logic [13:0] e;
        e = ref_verdict(s, c);
        @(posedge clk); #1;
        stored_code = s; calc_code = c; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 ready low while busy", in_ready == 1'b0, in_ready, 0);
        @(negedge clk);
        check("R7 ready back at done", in_ready == 1'b1, in_ready, 1);
        check(req, {status, err_offset, err_bit} == e, {status, err_offset, err_bit}, e);
        last_st = e[13:12]; last_ofs = e[11:3]; last_bit = e[2:0];
    endtask

    task automatic fix_case(input logic [7:0] b, input logic [8:0] o, input string req);
        logic [7:0] e;
        e = b;
        if (last_st == 2'd1 && o == last_ofs) e = b ^ (8'd1 << last_bit);
        @(posedge clk); #1;
        fix_in = b; fix_offset = o;
        @(negedge clk);
        check(req, fix_out == e, fix_out, e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset status", {status, err_offset, err_bit} == 14'd0, {status, err_offset, err_bit}, 0);
        check("R10 reset done", done == 1'b0, done, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready after reset", in_ready == 1'b1, in_ready, 1);

        run_case(24'hA53C96, 24'hA53C96, "R1 equal codes OK");
        run_case(err_code(0, 0), 24'h0, "R2 repair at offset 0 bit 0");
        fix_case(8'h55, 9'd0, "R8 flip at offset 0");
        fix_case(8'h55, 9'd1, "R9 neighbour unchanged");
        run_case(err_code(511, 7), 24'h0, "R2 repair at offset 511 bit 7");
        fix_case(8'h00, 9'd511, "R8 flip at offset 511");
        run_case(err_code(300, 5) ^ 24'h1234AB, 24'h1234AB, "R2 repair at offset 300 bit 5");
        fix_case(8'hFF, 9'd300, "R8 flip at offset 300");
        fix_case(8'hFF, 9'd299, "R9 offset mismatch unchanged");
        run_case(24'h000001, 24'h0, "R3 single bit byte0");
        fix_case(8'hC3, 9'd0, "R9 no flip after bad code");
        run_case(24'h000000, 24'h008000, "R3 single bit byte1");
        run_case(24'h040000, 24'h000000, "R3 single bit low nibble");
        run_case(24'h800000, 24'h000000, "R3 single bit high nibble");
        run_case(24'hFFFFFF, 24'h000000, "R4 erased page OK");
        run_case(24'hFFFFFF, 24'h000001, "R5 erased-like with nonzero code");
        run_case(24'h000000, 24'hFFFFFF, "R5 zero against all ones");
        run_case(24'h000003, 24'h000000, "R5 two bits");
        run_case(24'h000007, 24'h000000, "R1 R5 three bits");
        fix_case(8'h81, 9'd0, "R9 no flip after uncorrectable");
        run_case(24'h5A5A5A, 24'h5A5A5A, "R1 zero syndrome after errors");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule